// File: doc/BRIEF.md
# Raster LCD Controller Register File

This block is the software-visible register set of a simple raster LCD controller. It sits on a 32-bit, word-addressed bus with a 4 KB window. Software uses it to program four timing words, the upper and lower frame base addresses, a control word, an interrupt mask and an interrupt clear port. It can also read back raw and masked interrupt status, the current frame bases and an eight-byte identification table. One 128-word window is not stored here; accesses to it are forwarded to an external palette block.

Several values are decoded from the stored registers and driven out to the rest of the controller. The active column count comes from timing word 0 and the row count from timing word 1. From the control word come the display-enable qualifier, the pixel-depth code and the three ordering flags. A one-cycle strobe marks every change to timing or control, so that downstream logic can restart its frame. Interrupt sources lie outside the block. They set raw status bits through an input vector, and the block produces a single interrupt line from the masked bits.

A parameter selects one of three variants. In variant 0 the mask and control registers sit at their base offsets. Variants 1 and 2 swap those two offsets, and variant 2 also returns a different identification table.

Top module: `lcdc_regfile`

## Requirements
- R1: After reset, all timing, base, control, mask and raw-status registers hold zero. The column count is 16, the row count is 1, and `disp_en`, `irq` and `geom_chg` are low.
- R2: Word offsets 0–3 hold four 32-bit timing words that read back as written. Writing word 0 sets the column count to ((v & 0xFC) + 4) * 4. Writing word 1 sets the row count to (v & 0x3FF) + 1.
- R3: Word offsets 4 and 5 hold the upper and lower frame bases and drive `base_upper` and `base_lower`. Word offsets 11 and 12 read back the same two values.
- R4: With VARIANT 0, word 6 is the interrupt mask (IRQ_W bits) and word 7 is control. With VARIANT 1 or 2, the two offsets are swapped for both reads and writes.
- R5: Control keeps bits [11:0], and higher bits read as zero. `disp_en` is high only when bit 0 and bit 11 are both set. `pix_depth` is bits [3:1]. `bgr_order` is bit 8, `be_bytes` is bit 9 and `be_pixels` is bit 10.
- R6: In each cycle, raw status becomes (raw & ~clear) | irq_set. A write to word 10 supplies the clear bits, so a bit that is both set and cleared in the same cycle ends up set. Word 8 reads raw status and word 9 reads raw & mask. `irq` is high when any masked bit is set.
- R7: A read of byte offset 0xFE0 + 4k (k = 0..7) returns identification byte k. The table for variants 0 and 1 is 10 11 04 00 0D F0 05 B1, and the table for variant 2 is 11 11 24 00 0D F0 05 B1.
- R8: Byte offsets 0x200–0x3FC assert `pal_sel` in the request cycle, with `pal_index` equal to the word offset minus 128 and `pal_write` and `pal_wdata` following the request. A palette read returns `pal_rdata` in the response cycle.
- R9: A read of an undefined offset, including the write-only word 10, returns zero with `rd_err` high for that one response. Writes to undefined or read-only offsets change no state.
- R10: `geom_chg` pulses for exactly one cycle, the cycle after any write to words 0–3 or to control. No other access raises it.
- R11: Every read request is answered with `rd_valid` high in the next cycle, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address; bits [1:0] ignored |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| rd_err | output | 1 | Read hit an undefined offset |
| irq_set | input | IRQ_W | Raw status set pulses |
| irq | output | 1 | OR of masked status |
| pal_sel | output | 1 | Palette window access this cycle |
| pal_write | output | 1 | Palette access is a write |
| pal_index | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data, one cycle after request |
| cols | output | 11 | Active column count |
| rows | output | 11 | Active row count |
| disp_en | output | 1 | Enable and power both set |
| pix_depth | output | 3 | Pixel-depth code |
| bgr_order | output | 1 | Blue/red swap |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order |
| base_upper | output | 32 | Upper frame base |
| base_lower | output | 32 | Lower frame base |
| geom_chg | output | 1 | Timing or control was written |

## Verification
The assertions assume that the bus presents at most one request per cycle and that read and write are never combined in one request. They also assume that `irq_set` is a clean synchronous vector. The bench drives every request for exactly one cycle from the falling edge and returns `req_valid` low between requests. It holds `irq_set` at zero except in the single cycles that test setting and set-versus-clear priority. The palette model in the bench answers with the one-cycle latency that the response path expects.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  localparam int COL_W = 11;
  localparam int ROW_W = 11;
  localparam int CTRL_W = 12;
  localparam int PAL_IDX_W = 7;

  typedef enum logic [3:0] {
    RK_TIMING, RK_BASE_UP, RK_BASE_LO, RK_MASK, RK_CTRL, RK_RAW,
    RK_MASKED, RK_CLEAR, RK_CUR_UP, RK_CUR_LO, RK_PALETTE, RK_IDENT, RK_NONE
  } reg_kind_e;

  function automatic logic [COL_W-1:0] calc_cols(input logic [31:0] v);
    logic [COL_W-1:0] quads;
    quads = {3'b000, v[7:2], 2'b00} + 11'd4;
    return quads << 2;
  endfunction

  function automatic logic [ROW_W-1:0] calc_rows(input logic [31:0] v);
    return {1'b0, v[9:0]} + 11'd1;
  endfunction

  function automatic logic [7:0] ident_byte(input int variant, input logic [2:0] k);
    logic [7:0] b;
    case (k)
      3'd0: b = (variant == 2) ? 8'h11 : 8'h10;
      3'd1: b = 8'h11;
      3'd2: b = (variant == 2) ? 8'h24 : 8'h04;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/lcdc_addr_decode.sv
module lcdc_addr_decode
  import lcdc_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic [11:0]          addr,
  output reg_kind_e            kind,
  output logic [1:0]           tim_sel,
  output logic [PAL_IDX_W-1:0] pal_idx,
  output logic [2:0]           id_idx
);
  localparam bit SWAP = (VARIANT != 0);

  logic [9:0] word;
  assign word    = addr[11:2];
  assign tim_sel = word[1:0];
  assign pal_idx = word[PAL_IDX_W-1:0];
  assign id_idx  = word[2:0];

  always_comb begin
    if (word[9:7] == 3'b001) begin
      kind = RK_PALETTE;
    end else if (word[9:3] == 7'h7F) begin
      kind = RK_IDENT;
    end else begin
      case (word)
        10'd0, 10'd1, 10'd2, 10'd3: kind = RK_TIMING;
        10'd4:  kind = RK_BASE_UP;
        10'd5:  kind = RK_BASE_LO;
        10'd6:  kind = SWAP ? RK_CTRL : RK_MASK;
        10'd7:  kind = SWAP ? RK_MASK : RK_CTRL;
        10'd8:  kind = RK_RAW;
        10'd9:  kind = RK_MASKED;
        10'd10: kind = RK_CLEAR;
        10'd11: kind = RK_CUR_UP;
        10'd12: kind = RK_CUR_LO;
        default: kind = RK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lcdc_irq_status.sv
module lcdc_irq_status #(
  parameter int IRQ_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_i,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_wdata,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_wdata,
  output logic [IRQ_W-1:0] raw_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic [IRQ_W-1:0] masked_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] raw_q, mask_q, clr_bits;

  assign clr_bits = clr_we ? clr_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | set_i;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/lcdc_geometry.sv
module lcdc_geometry
  import lcdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tim_we,
  input  logic [1:0]        tim_sel,
  input  logic              ctrl_we,
  input  logic [31:0]       wdata,
  output logic [3:0][31:0]  tim_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [COL_W-1:0]  cols,
  output logic [ROW_W-1:0]  rows,
  output logic              geom_chg
);
  localparam logic [CTRL_W-1:0] CTRL_KEEP = {CTRL_W{1'b1}};

  for (genvar g = 0; g < 4; g++) begin : g_tim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tim_q[g] <= '0;
      else if (tim_we && tim_sel == 2'(g)) tim_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      cols     <= calc_cols(32'd0);
      rows     <= calc_rows(32'd0);
      geom_chg <= 1'b0;
    end else begin
      geom_chg <= tim_we || ctrl_we;
      if (ctrl_we) ctrl_q <= wdata[CTRL_W-1:0] & CTRL_KEEP;
      if (tim_we && tim_sel == 2'd0) cols <= calc_cols(wdata);
      if (tim_we && tim_sel == 2'd1) rows <= calc_rows(wdata);
    end
  end
endmodule

// File: rtl/lcdc_regfile.sv
module lcdc_regfile
  import lcdc_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int IRQ_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [11:0]          req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  output logic                 rd_err,
  input  logic [IRQ_W-1:0]     irq_set,
  output logic                 irq,
  output logic                 pal_sel,
  output logic                 pal_write,
  output logic [PAL_IDX_W-1:0] pal_index,
  output logic [31:0]          pal_wdata,
  input  logic [31:0]          pal_rdata,
  output logic [COL_W-1:0]     cols,
  output logic [ROW_W-1:0]     rows,
  output logic                 disp_en,
  output logic [2:0]           pix_depth,
  output logic                 bgr_order,
  output logic                 be_bytes,
  output logic                 be_pixels,
  output logic [31:0]          base_upper,
  output logic [31:0]          base_lower,
  output logic                 geom_chg
);
  reg_kind_e            kind;
  logic [1:0]           tim_sel;
  logic [PAL_IDX_W-1:0] pal_idx;
  logic [2:0]           id_idx;

  lcdc_addr_decode #(.VARIANT(VARIANT)) u_dec (
    .addr(req_addr), .kind(kind), .tim_sel(tim_sel),
    .pal_idx(pal_idx), .id_idx(id_idx)
  );

  logic wr_req, rd_req;
  logic wr_tim, wr_ctrl, wr_mask, wr_clr, wr_base_up, wr_base_lo;
  logic rd_bad, rd_pal;
  assign wr_req     = req_valid && req_write;
  assign rd_req     = req_valid && !req_write;
  assign wr_tim     = wr_req && kind == RK_TIMING;
  assign wr_ctrl    = wr_req && kind == RK_CTRL;
  assign wr_mask    = wr_req && kind == RK_MASK;
  assign wr_clr     = wr_req && kind == RK_CLEAR;
  assign wr_base_up = wr_req && kind == RK_BASE_UP;
  assign wr_base_lo = wr_req && kind == RK_BASE_LO;
  assign rd_bad     = rd_req && (kind == RK_NONE || kind == RK_CLEAR);
  assign rd_pal     = rd_req && kind == RK_PALETTE;

  logic [3:0][31:0]  tim_q;
  logic [CTRL_W-1:0] ctrl_q;

  lcdc_geometry u_geom (
    .clk(clk), .rst_n(rst_n), .tim_we(wr_tim), .tim_sel(tim_sel),
    .ctrl_we(wr_ctrl), .wdata(req_wdata), .tim_q(tim_q), .ctrl_q(ctrl_q),
    .cols(cols), .rows(rows), .geom_chg(geom_chg)
  );

  logic [IRQ_W-1:0] raw_st, mask_st, masked_st;

  lcdc_irq_status #(.IRQ_W(IRQ_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(irq_set),
    .mask_we(wr_mask), .mask_wdata(req_wdata[IRQ_W-1:0]),
    .clr_we(wr_clr), .clr_wdata(req_wdata[IRQ_W-1:0]),
    .raw_o(raw_st), .mask_o(mask_st), .masked_o(masked_st), .irq_o(irq)
  );

  logic [31:0] base_up_q, base_lo_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_up_q <= '0;
      base_lo_q <= '0;
    end else begin
      if (wr_base_up) base_up_q <= req_wdata;
      if (wr_base_lo) base_lo_q <= req_wdata;
    end
  end
  assign base_upper = base_up_q;
  assign base_lower = base_lo_q;

  assign disp_en   = ctrl_q[0] && ctrl_q[11];
  assign pix_depth = ctrl_q[3:1];
  assign bgr_order = ctrl_q[8];
  assign be_bytes  = ctrl_q[9];
  assign be_pixels = ctrl_q[10];

  assign pal_sel   = req_valid && kind == RK_PALETTE;
  assign pal_write = req_write;
  assign pal_index = pal_idx;
  assign pal_wdata = req_wdata;

  logic [31:0] rd_mux;
  always_comb begin
    case (kind)
      RK_TIMING:             rd_mux = tim_q[tim_sel];
      RK_BASE_UP, RK_CUR_UP: rd_mux = base_up_q;
      RK_BASE_LO, RK_CUR_LO: rd_mux = base_lo_q;
      RK_MASK:               rd_mux = 32'(mask_st);
      RK_CTRL:               rd_mux = 32'(ctrl_q);
      RK_RAW:                rd_mux = 32'(raw_st);
      RK_MASKED:             rd_mux = 32'(masked_st);
      RK_IDENT:              rd_mux = {24'd0, ident_byte(VARIANT, id_idx)};
      default:               rd_mux = '0;
    endcase
  end

  logic        rd_valid_q, rd_err_q, rd_pal_q;
  logic [31:0] rd_data_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_err_q   <= 1'b0;
      rd_pal_q   <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_req;
      rd_err_q   <= rd_bad;
      rd_pal_q   <= rd_pal;
      rd_data_q  <= rd_req ? rd_mux : '0;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_err   = rd_err_q;
  assign rd_data  = rd_pal_q ? pal_rdata : rd_data_q;
endmodule

// File: rtl/lcdc_regfile_chk.sv
module lcdc_regfile_chk #(
  parameter int IRQ_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [31:0]      req_wdata,
  input logic [IRQ_W-1:0] irq_set,
  input logic             rd_valid,
  input logic             rd_err,
  input logic [31:0]      rd_data,
  input logic [10:0]      cols,
  input logic [10:0]      rows,
  input logic             irq,
  input logic             geom_chg,
  input logic             disp_en,
  input logic             wr_tim,
  input logic             wr_ctrl,
  input logic             wr_clr
);
  assert_geom_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tim || wr_ctrl) |=> geom_chg);
  assert_geom_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_tim || wr_ctrl) |=> !geom_chg);
  assert_cols_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cols[3:0] == 4'd0) && (cols >= 11'd16) && (cols <= 11'd1024));
  assert_rows_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rows >= 11'd1) && (rows <= 11'd1024));
  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_valid && rd_data == 32'd0));
  assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);
  assert_rd_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);
  assert_enable_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_en) |-> $past(wr_ctrl));
  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && (&req_wdata[IRQ_W-1:0]) && irq_set == '0) |=> !irq);
endmodule

bind lcdc_regfile lcdc_regfile_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_wdata(req_wdata), .irq_set(irq_set), .rd_valid(rd_valid),
  .rd_err(rd_err), .rd_data(rd_data), .cols(cols), .rows(rows), .irq(irq),
  .geom_chg(geom_chg), .disp_en(disp_en), .wr_tim(wr_tim),
  .wr_ctrl(wr_ctrl), .wr_clr(wr_clr)
);

// File: tb/lcdc_regfile_test.sv
module lcdc_regfile_test;
  localparam int IRQ_W = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [IRQ_W-1:0] irq_set = '0;
  logic [31:0] pal_rdata;

  logic rd_valid, rd_err, irq, pal_sel, pal_write, geom_chg, disp_en;
  logic bgr_order, be_bytes, be_pixels;
  logic [31:0] rd_data, pal_wdata, base_upper, base_lower;
  logic [6:0] pal_index;
  logic [10:0] cols, rows;
  logic [2:0] pix_depth;

  logic a_rd_valid, a_rd_err, a_irq, a_pal_sel, a_pal_write, a_geom, a_en;
  logic a_bgr, a_beb, a_bep;
  logic [31:0] a_rd_data, a_pal_wdata, a_bu, a_bl;
  logic [6:0] a_pal_index;
  logic [10:0] a_cols, a_rows;
  logic [2:0] a_depth;

  lcdc_regfile #(.VARIANT(0), .IRQ_W(IRQ_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_err(rd_err), .irq_set(irq_set), .irq(irq),
    .pal_sel(pal_sel), .pal_write(pal_write), .pal_index(pal_index),
    .pal_wdata(pal_wdata), .pal_rdata(pal_rdata), .cols(cols), .rows(rows),
    .disp_en(disp_en), .pix_depth(pix_depth), .bgr_order(bgr_order),
    .be_bytes(be_bytes), .be_pixels(be_pixels), .base_upper(base_upper),
    .base_lower(base_lower), .geom_chg(geom_chg)
  );

  lcdc_regfile #(.VARIANT(2), .IRQ_W(IRQ_W)) uut_alt (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(a_rd_valid),
    .rd_data(a_rd_data), .rd_err(a_rd_err), .irq_set(irq_set), .irq(a_irq),
    .pal_sel(a_pal_sel), .pal_write(a_pal_write), .pal_index(a_pal_index),
    .pal_wdata(a_pal_wdata), .pal_rdata(32'd0), .cols(a_cols), .rows(a_rows),
    .disp_en(a_en), .pix_depth(a_depth), .bgr_order(a_bgr),
    .be_bytes(a_beb), .be_pixels(a_bep), .base_upper(a_bu),
    .base_lower(a_bl), .geom_chg(a_geom)
  );

  // palette model: one-cycle read latency
  logic [31:0] pal_mem [128];
  logic [6:0]  last_pal_idx;
  initial for (int i = 0; i < 128; i++) pal_mem[i] = 32'h0100_0000 + 32'(i);
  always @(posedge clk) begin
    if (pal_sel) begin
      last_pal_idx <= pal_index;
      if (pal_write) pal_mem[pal_index] <= pal_wdata;
      else pal_rdata <= pal_mem[pal_index];
    end
  end

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  logic [31:0] r_data, r_alt;
  logic r_err, r_val, r_aerr;
  task automatic bus_read(input logic [11:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    r_data = rd_data; r_err = rd_err; r_val = rd_valid;
    r_alt = a_rd_data; r_aerr = a_rd_err;
  endtask

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic        err;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h000, 32'h0000_00FF, 1'b0},
    '{1'b0, 12'h000, 32'h0000_00FF, 1'b0},
    '{1'b1, 12'h004, 32'h0000_0FFF, 1'b0},
    '{1'b0, 12'h004, 32'h0000_0FFF, 1'b0},
    '{1'b1, 12'h008, 32'h1234_5678, 1'b0},
    '{1'b0, 12'h008, 32'h1234_5678, 1'b0},
    '{1'b1, 12'h00C, 32'hCAFE_0001, 1'b0},
    '{1'b0, 12'h00C, 32'hCAFE_0001, 1'b0},
    '{1'b1, 12'h010, 32'h8000_0000, 1'b0},
    '{1'b0, 12'h010, 32'h8000_0000, 1'b0},
    '{1'b0, 12'h02C, 32'h8000_0000, 1'b0},
    '{1'b1, 12'h014, 32'h4000_1000, 1'b0},
    '{1'b0, 12'h014, 32'h4000_1000, 1'b0},
    '{1'b0, 12'h030, 32'h4000_1000, 1'b0},
    '{1'b1, 12'h018, 32'h0000_001F, 1'b0},
    '{1'b0, 12'h018, 32'h0000_001F, 1'b0},
    '{1'b1, 12'h01C, 32'hFFFF_F801, 1'b0},
    '{1'b0, 12'h01C, 32'h0000_0801, 1'b0},
    '{1'b0, 12'h034, 32'h0000_0000, 1'b1},
    '{1'b0, 12'h400, 32'h0000_0000, 1'b1},
    '{1'b0, 12'h028, 32'h0000_0000, 1'b1},
    '{1'b0, 12'hFE0, 32'h0000_0010, 1'b0},
    '{1'b0, 12'hFE8, 32'h0000_0004, 1'b0},
    '{1'b1, 12'h020, 32'h0000_00FF, 1'b0},
    '{1'b0, 12'h020, 32'h0000_0000, 1'b0}
  };

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cols", 32'(cols), 32'd16);
    chk("R1 rows", 32'(rows), 32'd1);
    chk("R1 outs", {29'd0, disp_en, irq, geom_chg}, 32'd0);
    bus_read(12'h000); chk("R1 timing0", r_data, 32'd0);
    bus_read(12'h01C); chk("R1 control", r_data, 32'd0);
    bus_read(12'h020); chk("R1 raw", r_data, 32'd0);

    // table walk: R2 R3 R4 R5 R7 R9 R11
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
      else begin
        bus_read(VECS[i].addr);
        chk("R11 rd_valid", {31'd0, r_val}, 32'd1);
        chk("R2/R3/R4/R5/R7 read data", r_data, VECS[i].data);
        chk("R9 rd_err", {31'd0, r_err}, {31'd0, VECS[i].err});
      end
    end
    chk("R2 cols max", 32'(cols), 32'd1024);
    chk("R2 rows max", 32'(rows), 32'd1024);
    chk("R3 base_upper", base_upper, 32'h8000_0000);
    chk("R3 base_lower", base_lower, 32'h4000_1000);
    chk("R5 disp_en both bits", {31'd0, disp_en}, 32'd1);

    // R2 / R10 geometry and strobe
    bus_write(12'h000, 32'h0000_0013);
    chk("R10 strobe after timing", {31'd0, geom_chg}, 32'd1);
    chk("R2 cols", 32'(cols), 32'd80);
    @(negedge clk);
    chk("R10 strobe one cycle", {31'd0, geom_chg}, 32'd0);
    bus_write(12'h004, 32'h0000_F40A);
    chk("R2 rows", 32'(rows), 32'd11);
    bus_write(12'h010, 32'h0000_1234);
    chk("R10 no strobe on base", {31'd0, geom_chg}, 32'd0);

    // R5 control fields
    bus_write(12'h01C, 32'h0000_0001);
    chk("R10 strobe after control", {31'd0, geom_chg}, 32'd1);
    chk("R5 enable only", {31'd0, disp_en}, 32'd0);
    bus_write(12'h01C, 32'h0000_0800);
    chk("R5 power only", {31'd0, disp_en}, 32'd0);
    bus_write(12'h01C, 32'h0000_0F0B);
    chk("R5 fields a", {26'd0, disp_en, pix_depth, bgr_order, be_bytes, be_pixels}, {26'd0, 1'b1, 3'd5, 1'b1, 1'b1, 1'b1});
    bus_write(12'h01C, 32'h0000_0A04);
    chk("R5 fields b", {26'd0, disp_en, pix_depth, bgr_order, be_bytes, be_pixels}, {26'd0, 1'b0, 3'd2, 1'b0, 1'b1, 1'b0});

    // R4 swapped variant, R7 alternate identification
    bus_write(12'h018, 32'h0000_0801);
    chk("R4 alt control at word 6", {31'd0, a_en}, 32'd1);
    bus_write(12'h01C, 32'h0000_0003);
    bus_read(12'h018);
    chk("R4 base word 6 mask", r_data, 32'h0000_0001);
    chk("R4 alt word 6 control", r_alt, 32'h0000_0801);
    bus_read(12'h01C);
    chk("R4 base word 7 control", r_data, 32'h0000_0003);
    chk("R4 alt word 7 mask", r_alt, 32'h0000_0003);
    bus_read(12'hFE0); chk("R7 alt id0", r_alt, 32'h11);
    bus_read(12'hFE8); chk("R7 alt id2", r_alt, 32'h24);
    bus_read(12'hFFC);
    chk("R7 id7", r_data, 32'hB1);
    chk("R7 alt id7", r_alt, 32'hB1);

    // R6 interrupt status
    bus_write(12'h018, 32'h0000_0005);
    @(negedge clk); irq_set = 5'h06;
    @(negedge clk); irq_set = 5'h00;
    chk("R6 irq on masked", {31'd0, irq}, 32'd1);
    bus_read(12'h020); chk("R6 raw", r_data, 32'h06);
    bus_read(12'h024); chk("R6 masked", r_data, 32'h04);
    bus_write(12'h028, 32'h0000_0004);
    chk("R6 irq after clear", {31'd0, irq}, 32'd0);
    bus_read(12'h020); chk("R6 raw after clear", r_data, 32'h02);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h028; req_wdata = 32'h1; irq_set = 5'h01;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; irq_set = 5'h00;
    chk("R6 set wins irq", {31'd0, irq}, 32'd1);
    bus_read(12'h020); chk("R6 set wins raw", r_data, 32'h03);
    bus_write(12'h028, 32'h0000_001F);
    bus_read(12'h020); chk("R6 clear all", r_data, 32'h00);

    // R8 palette forwarding
    bus_write(12'h204, 32'h0000_ABCD);
    chk("R8 pal index", 32'(last_pal_idx), 32'd1);
    chk("R8 pal stored", pal_mem[1], 32'h0000_ABCD);
    bus_read(12'h204); chk("R8 pal read back", r_data, 32'h0000_ABCD);
    bus_read(12'h3FC); chk("R8 pal last", r_data, 32'h0100_007F);
    chk("R8 pal idx last", 32'(last_pal_idx), 32'd127);

    // R9 writes to undefined / read-only offsets ignored
    bus_write(12'h034, 32'hFFFF_FFFF);
    chk("R9 no strobe undefined", {31'd0, geom_chg}, 32'd0);
    bus_write(12'h024, 32'hFFFF_FFFF);
    bus_write(12'h02C, 32'hFFFF_FFFF);
    bus_read(12'h010); chk("R9 base untouched", r_data, 32'h0000_1234);
    bus_read(12'h024); chk("R9 masked untouched", r_data, 32'h0);
    bus_read(12'h000); chk("R9 timing untouched", r_data, 32'h0000_0013);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule